// File: doc/BRIEF.md
# Serial Converter Power-State Sequencer

This block tracks the power condition of a serial-interface data converter. It watches a chip-select, serial-clock and data line, all sampled in the system clock domain. From the 16-bit control word that arrives during a frame it keeps a two-bit power-management mode, a reference-off flag and a dual-channel flag. The analog conversion is not modelled. A conversion is treated as the frame of serial-clock cycles itself.

The chip-select and serial-clock edges that power the block down or wake it up depend on the mode. In the gated mode, chip-select itself controls the power. In the two automatic modes, the frame's serial-clock edges control it. In the full-on mode the block never powers down. A wake passes through a waking state whose length in system-clock cycles depends on the state being left. The ready flag is high only in the active state. A reference-select code reports which reference the converter would use.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset the mode is 00, the reference-off and dual-channel flags are clear, `pwr_state` is shutdown (3), `ready` is 0 and `ref_sel` is 00.
- R2: While chip-select is low, one bit of the control word is shifted in MSB first on each rising serial-clock edge. Of the last 16 bits shifted, bits [1:0] are the mode, bit 2 is reference-off and bit 3 is dual-channel. These settings take effect when chip-select rises.
- R3: A frame with fewer than 16 rising serial-clock edges leaves all settings unchanged.
- R4: In mode 00, a chip-select rise moves the block to shutdown at once, even partway through a frame. A chip-select fall while powered down starts a wake.
- R5: In modes 01 and 10, a wake is started by the first falling serial-clock edge after chip-select falls. A chip-select fall on its own does not start one.
- R6: In modes 01 and 10, the 16th rising serial-clock edge after chip-select falls moves the block to standby (mode 01) or shutdown (mode 10) while chip-select is still low. If chip-select rises before that edge, the block stays active.
- R7: In mode 11 the block never powers down. A chip-select fall while powered down starts a wake.
- R8: The power action taken at a chip-select rise follows the mode that was in force during that frame, not the mode the frame programs.
- R9: A wake from standby lasts WAKE_SHORT cycles. A wake from shutdown lasts WAKE_LONG cycles, unless `ref_sel` is not 00, in which case it lasts WAKE_SHORT cycles. `ready` rises exactly when the wake ends.
- R10: `ref_sel` is 10 (supply) when dual-channel is set, whatever reference-off holds. Otherwise it is 01 (external) when reference-off is set and 00 (internal) when it is clear.
- R11: `pwr_state` encodes active as 0, waking as 1, standby as 2 and shutdown as 3. `ready` is 1 only in the active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data in, sampled on rising serial-clock edges |
| pwr_state | output | 2 | Power state: 0 active, 1 waking, 2 standby, 3 shutdown |
| ready | output | 1 | High when the converter is powered and settled |
| ref_sel | output | 2 | Reference source: 0 internal, 1 external, 2 supply |

## Verification
A chip-select rise can do two things in the same system-clock cycle. It can load new settings from a full frame, and in mode 00 it also triggers the shutdown. The bench provokes this by running frames that reprogram the mode. A frame written in mode 00 must end in shutdown even when it selects an automatic or full-on mode. A frame written in mode 11 must stay active even when it selects mode 00. The following frame then shows that the new mode took effect only after that edge.

// File: rtl/adc_pwr_seq_pkg.sv
package adc_pwr_seq_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_WAKE   = 2'd1,
    PS_STBY   = 2'd2,
    PS_SHDN   = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    PM_GATED     = 2'b00,
    PM_AUTO_STBY = 2'b01,
    PM_AUTO_SHDN = 2'b10,
    PM_FULL_ON   = 2'b11
  } pmode_e;

  typedef enum logic [1:0] {
    REF_INTERNAL = 2'd0,
    REF_EXTERNAL = 2'd1,
    REF_SUPPLY   = 2'd2
  } refsel_e;

  // Low nibble of the control word, in bit order: dual, ref_off, mode[1:0]
  typedef struct packed {
    logic   dual;
    logic   ref_off;
    pmode_e pm;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/adc_pwr_seq_frame.sv
module adc_pwr_seq_frame
  import adc_pwr_seq_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic cs_fall,
  output logic cs_rise,
  output logic first_fall,
  output logic frame_end,
  output cfg_t cfg
);

  localparam int CW = $clog2(FRAME_BITS + 1);

  logic cs_q1, cs_q2, sck_q1, sck_q2, sdi_q1;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  seen_q, seen_d;
  cfg_t                  cfg_q, cfg_d;
  logic                  sck_rise, sck_fall, cnt_en, sh_en, cfg_en;

  // input sampling registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q1  <= 1'b1;
      cs_q2  <= 1'b1;
      sck_q1 <= 1'b1;
      sck_q2 <= 1'b1;
      sdi_q1 <= 1'b0;
    end else begin
      cs_q1  <= cs_n;
      cs_q2  <= cs_q1;
      sck_q1 <= sclk;
      sck_q2 <= sck_q1;
      sdi_q1 <= sdi;
    end
  end

  always_comb begin
    cs_fall   = cs_q2 & ~cs_q1;
    cs_rise   = ~cs_q2 & cs_q1;
    sck_rise  = sck_q1 & ~sck_q2 & ~cs_q1;
    sck_fall  = ~sck_q1 & sck_q2 & ~cs_q1;
    first_fall = sck_fall & ~seen_q;
    frame_end  = sck_rise & (cnt_q == CW'(FRAME_BITS - 1));

    cnt_en = cs_fall | (sck_rise & (cnt_q != CW'(FRAME_BITS)));
    cnt_d  = cs_fall ? '0 : cnt_q + CW'(1);

    sh_en = sck_rise;
    sh_d  = {sh_q[FRAME_BITS-2:0], sdi_q1};

    seen_d = ~cs_fall;

    cfg_en = cs_rise & (cnt_q == CW'(FRAME_BITS));
    cfg_d  = cfg_t'(sh_q[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      seen_q <= 1'b0;
      cfg_q  <= '{dual: 1'b0, ref_off: 1'b0, pm: PM_GATED};
    end else begin
      if (cnt_en)             cnt_q  <= cnt_d;
      if (sh_en)              sh_q   <= sh_d;
      if (cs_fall | sck_fall) seen_q <= seen_d;
      if (cfg_en)             cfg_q  <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(cfg_q)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FRAME_BITS)); // R2

endmodule

// File: rtl/adc_pwr_seq_fsm.sv
module adc_pwr_seq_fsm
  import adc_pwr_seq_pkg::*;
#(
  parameter int WAKE_SHORT = 100,
  parameter int WAKE_LONG  = 500
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_fall,
  input  logic    cs_rise,
  input  logic    first_fall,
  input  logic    frame_end,
  input  cfg_t    cfg,
  input  logic    short_ref,
  output pstate_e state,
  output logic    ready
);

  localparam int WMAX = (WAKE_LONG > WAKE_SHORT) ? WAKE_LONG : WAKE_SHORT;
  localparam int WW   = $clog2(WMAX + 1);

  pstate_e        st_q, st_d;
  logic [WW-1:0]  wc_q, wc_d;
  logic           wc_en, pd_ev, wk_ev, down;
  pstate_e        pd_tgt;

  always_comb begin
    pd_ev  = 1'b0;
    wk_ev  = 1'b0;
    pd_tgt = PS_SHDN;
    unique case (cfg.pm)
      PM_GATED: begin
        pd_ev = cs_rise;
        wk_ev = cs_fall;
      end
      PM_AUTO_STBY: begin
        pd_ev  = frame_end;
        wk_ev  = first_fall;
        pd_tgt = PS_STBY;
      end
      PM_AUTO_SHDN: begin
        pd_ev = frame_end;
        wk_ev = first_fall;
      end
      default: begin
        wk_ev = cs_fall;
      end
    endcase

    down  = (st_q == PS_STBY) | (st_q == PS_SHDN);
    st_d  = st_q;
    wc_en = 1'b0;
    wc_d  = wc_q - WW'(1);

    if (pd_ev) begin
      st_d = pd_tgt;
    end else if (wk_ev && down) begin
      st_d  = PS_WAKE;
      wc_en = 1'b1;
      wc_d  = ((st_q == PS_STBY) || short_ref) ? WW'(WAKE_SHORT - 1)
                                               : WW'(WAKE_LONG - 1);
    end else if (st_q == PS_WAKE) begin
      wc_en = 1'b1;
      if (wc_q == '0) st_d = PS_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_SHDN;
      wc_q <= '0;
    end else begin
      st_q <= st_d;
      if (wc_en) wc_q <= wc_d;
    end
  end

  assign state = st_q;
  assign ready = (st_q == PS_ACTIVE);

  AST_GATED_SHDN: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cfg.pm == PM_GATED) |=> (st_q == PS_SHDN)); // R4
  AST_AUTO_STBY_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cfg.pm == PM_AUTO_STBY) |=> (st_q == PS_STBY)); // R6
  AST_FULL_ON_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.pm == PM_FULL_ON && st_q == PS_ACTIVE) |=> (st_q == PS_ACTIVE)); // R7
  AST_READY_VIA_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(st_q) == PS_WAKE)); // R9

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_seq_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int WAKE_SHORT = 100,
  parameter int WAKE_LONG  = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic [1:0] pwr_state,
  output logic       ready,
  output logic [1:0] ref_sel
);

  logic [1:0] rst_sync;
  logic       rst_n_s;
  logic       cs_fall, cs_rise, first_fall, frame_end, short_ref;
  cfg_t       cfg;
  pstate_e    st;
  refsel_e    ref_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  adc_pwr_seq_frame #(.FRAME_BITS(FRAME_BITS)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .sdi        (sdi),
    .cs_fall    (cs_fall),
    .cs_rise    (cs_rise),
    .first_fall (first_fall),
    .frame_end  (frame_end),
    .cfg        (cfg)
  );

  always_comb begin
    if (cfg.dual)         ref_d = REF_SUPPLY;
    else if (cfg.ref_off) ref_d = REF_EXTERNAL;
    else                  ref_d = REF_INTERNAL;
    short_ref = (ref_d != REF_INTERNAL);
  end

  adc_pwr_seq_fsm #(.WAKE_SHORT(WAKE_SHORT), .WAKE_LONG(WAKE_LONG)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cs_fall    (cs_fall),
    .cs_rise    (cs_rise),
    .first_fall (first_fall),
    .frame_end  (frame_end),
    .cfg        (cfg),
    .short_ref  (short_ref),
    .state      (st),
    .ready      (ready)
  );

  assign pwr_state = st;
  assign ref_sel   = ref_d;

  AST_REF_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cs_rise |=> $stable(ref_sel)); // R10

endmodule

// File: tb/adc_pwr_seq_tb_top.sv
module adc_pwr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WS = 8;
  localparam int WL = 40;
  localparam int HALF = 4;

  logic       clk, rst_n, cs_n, sclk, sdi;
  logic [1:0] pwr_state, ref_sel;
  logic       ready;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  adc_pwr_seq #(.FRAME_BITS(16), .WAKE_SHORT(WS), .WAKE_LONG(WL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .pwr_state(pwr_state), .ready(ready), .ref_sel(ref_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // word[24:9], bits[8:4], expected state[3:2], expected ref_sel[1:0]
  localparam logic [24:0] VEC [8] = '{
    {16'h0001, 5'd16, 2'd3, 2'd0},  // R8 mode00 frame picks 01 -> shutdown
    {16'h0002, 5'd16, 2'd2, 2'd0},  // R6 mode01 frame -> standby
    {16'h0006, 5'd16, 2'd3, 2'd1},  // R6 mode10 frame -> shutdown, R10 ext
    {16'h000B, 5'd16, 2'd3, 2'd2},  // R10 dual overrides
    {16'h0003, 5'd16, 2'd0, 2'd0},  // R7 full-on wakes and stays
    {16'h0380, 5'd9,  2'd0, 2'd0},  // R3 partial frame ignored
    {16'h0000, 5'd16, 2'd0, 2'd0},  // R8 mode11 frame picks 00 -> stays
    {16'h0000, 5'd16, 2'd3, 2'd0}   // R4 mode00 -> shutdown
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b0; sdi = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic send_frame(input logic [15:0] w, input int nb);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nb; i++) send_bit(w[15-i]);
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  // counts negedges spent in the waking state
  task automatic measure_wake(output int n);
    int guard;
    n = 0; guard = 0;
    while (pwr_state != 2'd1 && guard < 20) begin wait_clk(1); guard++; end
    while (pwr_state == 2'd1 && n < 1000) begin n++; wait_clk(1); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0;
    wait_clk(3);
    check("R1 state", pwr_state, 3);
    check("R1 ready", ready, 0);
    check("R1 ref_sel", ref_sel, 0);
    rst_n = 1'b1;
    wait_clk(4);
    check("R1 state after release", pwr_state, 3);

    for (int v = 0; v < 8; v++) begin
      send_frame(VEC[v][24:9], int'(VEC[v][8:4]));
      check($sformatf("R2 vec%0d state", v), pwr_state, int'(VEC[v][3:2]));
      check($sformatf("R10 vec%0d ref", v), ref_sel, int'(VEC[v][1:0]));
    end

    // mode 00, internal ref: long wake on chip-select fall, then mid-frame abort
    cs_n = 1'b0;
    measure_wake(n);
    check("R9 long wake from shutdown", n, WL);
    check("R11 ready when active", ready, 1);
    check("R4 active during frame", pwr_state, 0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    cs_n = 1'b1;
    wait_clk(3);
    check("R4 mid-frame abort shutdown", pwr_state, 3);
    check("R3 partial frame ref unchanged", ref_sel, 0);
    wait_clk(6);

    // program external reference in mode 00, then short wake from shutdown
    send_frame(16'h0004, 16);
    check("R10 external ref", ref_sel, 1);
    cs_n = 1'b0;
    measure_wake(n);
    check("R9 short wake with external ref", n, WS);
    cs_n = 1'b1;
    wait_clk(10);

    // program mode 01 with internal reference
    send_frame(16'h0001, 16);
    check("R4 shutdown after frame", pwr_state, 3);
    cs_n = 1'b0;
    wait_clk(20);
    check("R5 chip-select fall alone no wake", pwr_state, 3);
    sclk = 1'b0; sdi = 1'b0;
    measure_wake(n);
    check("R5 R9 first fall long wake", n, WL);
    sclk = 1'b1;
    wait_clk(HALF);
    for (int i = 14; i >= 1; i--) send_bit(1'b0);
    check("R6 active after 15 rises", pwr_state, 0);
    send_bit(1'b1);
    check("R6 standby on 16th rise cs low", pwr_state, 2);
    check("R11 ready low in standby", ready, 0);
    cs_n = 1'b1;
    wait_clk(10);

    // mode 01 from standby: short wake, early chip-select rise keeps active
    cs_n = 1'b0;
    wait_clk(HALF);
    sclk = 1'b0;
    measure_wake(n);
    check("R9 short wake from standby", n, WS);
    sclk = 1'b1;
    wait_clk(HALF);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    cs_n = 1'b1;
    wait_clk(10);
    check("R6 early cs rise stays active", pwr_state, 0);
    check("R3 settings kept", ref_sel, 0);

    // reset in the middle of operation
    rst_n = 1'b0;
    wait_clk(2);
    check("R1 reset state", pwr_state, 3);
    check("R1 reset ready", ready, 0);
    rst_n = 1'b1;
    wait_clk(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule